// File: doc/BRIEF.md
# Pipelined In-Order Store Commit Queue

This block sits between the retirement stage of a core and a shared, banked second-level cache. Retired stores, each an address and a data word, are written into a circular queue. They leave it for the cache in program order through a split handshake. First the queue sends the store address and the entry tag as a request. The cache bank then returns an acknowledge, or a negative acknowledge when the line is missing. Finally the queue sends the store data a fixed number of cycles after the acknowledge. Because the cache does not need to finish one store before the next request goes out, a new store can enter this handshake on every cycle. Many stores can therefore be in flight at once.

A negative acknowledge means the line is not present. The queue then cancels the missing store and every younger store that is still waiting for a response, and it issues no further requests. Once the cache signals that it has fetched the line, the queue sends the requests again, starting at the entry that missed. An entry is freed only in the cycle its data is written to the cache, so stores become globally visible in queue order. The environment returns responses in request order. It raises the retry strobe only after it has answered every request issued before the miss.

Top module: `store_commit_queue`

## Requirements
- R1: During and right after reset the queue is empty: `queueFull`, `reqValid` and `dataValid` are all 0.
- R2: A store is accepted on a rising edge where `enqValid` is 1 and `queueFull` is 0. `queueFull` is 1 exactly when DEPTH entries are held, and an enqueue offered while it is 1 is dropped and never reaches the cache.
- R3: Requests leave in queue order, at most one per cycle and back to back when possible. `reqTag` is the entry index, which counts up from 0 after reset and wraps at DEPTH. `reqAddr` is the address of that entry.
- R4: For an accepted acknowledge (`rspValid`=1, `rspNack`=0) presented in cycle c, `dataValid` is 1 in cycle c+ACK_TO_DATA, carrying that tag together with the store's address and data.
- R5: Data writes happen in exactly the order stores were accepted, and each accepted store is written once.
- R6: A negative acknowledge (`rspNack`=1) for an outstanding tag cancels that store and all younger outstanding stores. No request is issued in that cycle or any later cycle up to and including the cycle in which `retryValid` is 1.
- R7: The first request after the retry carries the tag of the store that missed. The younger stores follow in order.
- R8: A response whose tag has no outstanding request, such as one that answers a cancelled request, is ignored: it produces no data write and causes no cancellation.
- R9: An entry is released at the clock edge that ends its data cycle. While the queue is full and no data is being written, `queueFull` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enqValid | input | 1 | Retired store offered for enqueue |
| enqAddr | input | ADDR_W | Address of the offered store |
| enqData | input | DATA_W | Data of the offered store |
| queueFull | output | 1 | All DEPTH entries are occupied; retirement of stores must halt |
| reqValid | output | 1 | Address request to the cache this cycle |
| reqTag | output | log2(DEPTH) | Entry index of the request |
| reqAddr | output | ADDR_W | Store address of the request |
| rspValid | input | 1 | Response from the cache this cycle |
| rspNack | input | 1 | 1 = line missing (negative acknowledge), 0 = line locked (acknowledge) |
| rspTag | input | log2(DEPTH) | Entry index the response refers to |
| retryValid | input | 1 | The missing line is now present; cancelled stores may be reissued |
| dataValid | output | 1 | Store data transfer to the cache this cycle |
| dataTag | output | log2(DEPTH) | Entry index of the data transfer |
| dataAddr | output | ADDR_W | Address of the store being written |
| dataValue | output | DATA_W | Data of the store being written |

## Verification
The bench sweeps the position of a single missing line across every slot of an eight-store burst, including the case with no miss, under both a one-cycle and a three-cycle cache response latency. A miss at the oldest slot shows whether nothing at all is written before the retry. A miss at the youngest slot shows whether the older stores drain untouched. Slots in between show whether acknowledged-but-older stores keep their fixed data delay while younger acknowledges are discarded. Bursts with two missing lines, and a burst of nine stores under a long latency, show stale-response filtering, pointer wrap across runs, the dropped enqueue and the exact cycle in which the full flag clears.

// File: rtl/scq_pkg.sv
package scq_pkg;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic wrEn;     // capture the retiring store into the tail entry
    logic issueEn;  // an address request leaves this cycle
    logic dataEn;   // a data transfer leaves this cycle
  } scqStrobeT;

endpackage

// File: rtl/scq_datapath.sv
module scq_datapath
  import scq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  scqStrobeT         strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] enqAddr,
  input  logic [DATA_W-1:0] enqData,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [IDX_W-1:0]  dataIdx,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [DATA_W-1:0] dataValue
);

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      addrMem[wrIdx] <= enqAddr;
      dataMem[wrIdx] <= enqData;
    end
  end

  // Outputs are held at zero when their channel is idle.
  always_comb begin
    reqAddr   = strb.issueEn ? addrMem[reqIdx]  : '0;
    dataAddr  = strb.dataEn  ? addrMem[dataIdx] : '0;
    dataValue = strb.dataEn  ? dataMem[dataIdx] : '0;
  end

endmodule

// File: rtl/scq_control.sv
module scq_control
  import scq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int ACK_TO_DATA = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enqValid,
  input  logic             rspValid,
  input  logic             rspNack,
  input  logic [IDX_W-1:0] rspTag,
  input  logic             retryValid,
  output logic             queueFull,
  output logic             reqValid,
  output logic [IDX_W-1:0] reqTag,
  output logic             dataValid,
  output logic [IDX_W-1:0] dataTag,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic             nackTaken,
  output scqStrobeT        strb
);

  // Pointers carry one wrap bit so that full and empty differ.
  logic [PTR_W-1:0] headPtr, issuePtr, tailPtr, rewindPtr;
  logic [IDX_W-1:0] rewindDist;
  logic [DEPTH-1:0] sentVec, sentNext;
  logic             stalled;
  logic             enqFire, rspHit, ackTaken, issueOk;

  logic             pipeVld [ACK_TO_DATA];
  logic [IDX_W-1:0] pipeTag [ACK_TO_DATA];

  assign queueFull = (tailPtr - headPtr) == PTR_W'(DEPTH);
  assign enqFire   = enqValid && !queueFull;

  // Only a response to an outstanding request counts.
  assign rspHit    = rspValid && sentVec[rspTag];
  assign ackTaken  = rspHit && !rspNack;
  assign nackTaken = rspHit && rspNack;

  assign issueOk   = (issuePtr != tailPtr) && !stalled && !nackTaken;
  assign reqValid  = issueOk;
  assign reqTag    = issuePtr[IDX_W-1:0];

  assign dataValid = pipeVld[ACK_TO_DATA-1];
  assign dataTag   = pipeTag[ACK_TO_DATA-1];

  assign wrIdx     = tailPtr[IDX_W-1:0];
  assign headIdx   = headPtr[IDX_W-1:0];

  // Distance from the head to the missing entry, turned back into a full pointer.
  assign rewindDist = rspTag - headPtr[IDX_W-1:0];
  assign rewindPtr  = headPtr + PTR_W'(rewindDist);

  always_comb begin
    strb.wrEn    = enqFire;
    strb.issueEn = issueOk;
    strb.dataEn  = dataValid;
  end

  always_comb begin
    sentNext = sentVec;
    if (nackTaken) begin
      sentNext = '0;  // miss and everything younger loses its request
    end else begin
      if (ackTaken) sentNext[rspTag] = 1'b0;
      if (issueOk)  sentNext[reqTag] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr  <= '0;
      issuePtr <= '0;
      tailPtr  <= '0;
      sentVec  <= '0;
      stalled  <= 1'b0;
    end else begin
      sentVec <= sentNext;
      if (enqFire)   tailPtr <= tailPtr + 1'b1;
      if (dataValid) headPtr <= headPtr + 1'b1;
      if (nackTaken) begin
        issuePtr <= rewindPtr;
        stalled  <= 1'b1;
      end else begin
        if (issueOk)    issuePtr <= issuePtr + 1'b1;
        if (retryValid) stalled  <= 1'b0;
      end
    end
  end

  // Fixed acknowledge-to-data delay line, one stage per cycle.
  for (genvar s = 0; s < ACK_TO_DATA; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipeVld[0] <= 1'b0;
        else       pipeVld[0] <= ackTaken;
      end
      always_ff @(posedge clk) pipeTag[0] <= rspTag;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipeVld[s] <= 1'b0;
        else       pipeVld[s] <= pipeVld[s-1];
      end
      always_ff @(posedge clk) pipeTag[s] <= pipeTag[s-1];
    end
  end

endmodule

// File: rtl/store_commit_queue.sv
module store_commit_queue
  import scq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int ACK_TO_DATA = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [ADDR_W-1:0] enqAddr,
  input  logic [DATA_W-1:0] enqData,
  output logic              queueFull,
  output logic              reqValid,
  output logic [IDX_W-1:0]  reqTag,
  output logic [ADDR_W-1:0] reqAddr,
  input  logic              rspValid,
  input  logic              rspNack,
  input  logic [IDX_W-1:0]  rspTag,
  input  logic              retryValid,
  output logic              dataValid,
  output logic [IDX_W-1:0]  dataTag,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [DATA_W-1:0] dataValue
);

  scqStrobeT        strb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] headIdx;
  logic             nackTaken;

  scq_control #(.DEPTH(DEPTH), .ACK_TO_DATA(ACK_TO_DATA)) u_ctrl (
    .clk(clk), .rstN(rstN), .enqValid(enqValid),
    .rspValid(rspValid), .rspNack(rspNack), .rspTag(rspTag),
    .retryValid(retryValid), .queueFull(queueFull),
    .reqValid(reqValid), .reqTag(reqTag),
    .dataValid(dataValid), .dataTag(dataTag),
    .wrIdx(wrIdx), .headIdx(headIdx), .nackTaken(nackTaken), .strb(strb)
  );

  scq_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .strb(strb), .wrIdx(wrIdx),
    .enqAddr(enqAddr), .enqData(enqData),
    .reqIdx(reqTag), .dataIdx(dataTag),
    .reqAddr(reqAddr), .dataAddr(dataAddr), .dataValue(dataValue)
  );

endmodule

// File: rtl/scq_checker.sv
module scq_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             queueFull,
  input logic             reqValid,
  input logic [IDX_W-1:0] reqTag,
  input logic             dataValid,
  input logic [IDX_W-1:0] dataTag,
  input logic [IDX_W-1:0] headIdx,
  input logic             nackTaken
);

  // R9: a full queue stays full until a data write frees the head.
  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (queueFull && !dataValid) |=> queueFull);

  // R5: every data write belongs to the oldest entry.
  a_r5_data_from_head: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> (dataTag == headIdx));

  // R6: no request in the cycle after an accepted miss.
  a_r6_quiet_after_nack: assert property (@(posedge clk) disable iff (!rstN)
    nackTaken |=> !reqValid);

  // R3: back-to-back requests carry consecutive tags.
  a_r3_tags_consecutive: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && $past(reqValid)) |-> (reqTag == IDX_W'($past(reqTag) + 1'b1)));

endmodule

bind store_commit_queue scq_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .queueFull(queueFull), .reqValid(reqValid),
  .reqTag(reqTag), .dataValid(dataValid), .dataTag(dataTag),
  .headIdx(headIdx), .nackTaken(nackTaken)
);

// File: tb/sim_store_commit_queue.sv
module sim_store_commit_queue;

  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int DW    = 16;
  localparam int A2D   = 2;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enqValid = 1'b0;
  logic [AW-1:0] enqAddr = '0;
  logic [DW-1:0] enqData = '0;
  logic          queueFull, reqValid, dataValid;
  logic [IW-1:0] reqTag, dataTag;
  logic [AW-1:0] reqAddr, dataAddr;
  logic [DW-1:0] dataValue;
  logic          rspValid = 1'b0, rspNack = 1'b0, retryValid = 1'b0;
  logic [IW-1:0] rspTag = '0;

  store_commit_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .ACK_TO_DATA(A2D)) u0 (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqAddr(enqAddr), .enqData(enqData),
    .queueFull(queueFull), .reqValid(reqValid), .reqTag(reqTag), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspNack(rspNack), .rspTag(rspTag), .retryValid(retryValid),
    .dataValid(dataValid), .dataTag(dataTag), .dataAddr(dataAddr), .dataValue(dataValue)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct { logic [IW-1:0] tag; logic [AW-1:0] addr; int due; } pendT;

  int            cyc = 0;
  int            nChecks = 0, nFails = 0;
  bit            done = 0;
  pendT          pendQ[$];
  logic [31:0]   expQ[$];
  int            expCyc[$];
  bit            owned [256];
  logic [AW-1:0] tagAddr [DEPTH];
  logic [IW-1:0] tailTag = '0;
  bit            stale = 0, expReissue = 0;
  logic [IW-1:0] missTag = '0;
  int            retryAt = 0, rspLat = 1, writes = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string msg);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Cache model and output monitor, both working away from the rising edge.
  always @(negedge clk) begin
    bit clearStale;
    clearStale = 0;
    rspValid = 0; rspNack = 0; retryValid = 0;
    if (rstN) begin
      if (pendQ.size() > 0 && pendQ[0].due <= cyc) begin
        pendT p;
        bit miss;
        p = pendQ.pop_front();
        miss = !owned[p.addr[7:0]];
        rspValid = 1; rspTag = p.tag; rspNack = miss;
        if (miss) owned[p.addr[7:0]] = 1;
        if (!stale) begin
          if (miss) begin
            stale = 1; missTag = p.tag; expReissue = 1; retryAt = cyc + 3;
          end else begin
            expCyc.push_back(cyc + A2D);
          end
        end
      end else if (stale && pendQ.size() == 0 && cyc >= retryAt) begin
        retryValid = 1; clearStale = 1;
      end
      #1;
      if (reqValid) begin
        pendT q;
        chk(!stale, "R6", $sformatf("request tag %0d while cancelled, got 1 exp 0", reqTag));
        chk(reqAddr == tagAddr[reqTag], "R3",
            $sformatf("reqAddr got %h exp %h", reqAddr, tagAddr[reqTag]));
        if (expReissue) begin
          chk(reqTag == missTag, "R7", $sformatf("reissue tag got %0d exp %0d", reqTag, missTag));
          expReissue = 0;
        end
        q.tag = reqTag; q.addr = reqAddr; q.due = cyc + rspLat;
        pendQ.push_back(q);
      end
      if (dataValid) begin
        writes++;
        if (expQ.size() == 0) begin
          chk(0, "R5", $sformatf("unexpected write got %h exp none", {dataAddr, dataValue}));
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          chk({dataAddr, dataValue} == e, "R5",
              $sformatf("write got %h exp %h", {dataAddr, dataValue}, e));
        end
        if (expCyc.size() == 0) begin
          chk(0, "R4", $sformatf("data cycle got %0d exp none (R8 stale ack)", cyc));
        end else begin
          int ec;
          ec = expCyc.pop_front();
          chk(ec == cyc, "R4", $sformatf("data cycle got %0d exp %0d", cyc, ec));
        end
      end
      if (clearStale) stale = 0;
    end
  end

  task automatic runBurst(input int sc, input int lat, input logic [8:0] missMask,
                          input int n, input bit probeFull);
    int accepted, startWrites;
    bit drained;
    rspLat = lat;
    accepted = 0;
    startWrites = writes;
    for (int i = 0; i < n; i++) begin
      logic [7:0] lo;
      lo = 8'((sc * 9 + i) % 256);
      owned[lo] = !missMask[i];
      @(negedge clk);
      enqValid = 1;
      enqAddr  = {8'(sc), lo};
      enqData  = 16'(sc * 256 + i * 17 + 5);
      if (probeFull && i == DEPTH)
        chk(queueFull == 1'b1, "R2", $sformatf("queueFull got %0b exp 1", queueFull));
      if (!queueFull) begin
        expQ.push_back({enqAddr, enqData});
        tagAddr[tailTag] = enqAddr;
        tailTag++;
        accepted++;
      end
    end
    @(negedge clk);
    enqValid = 0;
    if (probeFull) begin
      chk(accepted == DEPTH, "R2", $sformatf("accepted got %0d exp %0d", accepted, DEPTH));
      for (int w = 0; w < 400 && !dataValid; w++) @(negedge clk);
      chk(queueFull == 1'b1, "R9", $sformatf("full in first data cycle got %0b exp 1", queueFull));
      @(negedge clk);
      chk(queueFull == 1'b0, "R9", $sformatf("full after first write got %0b exp 0", queueFull));
    end
    drained = 0;
    for (int w = 0; w < 800 && !drained; w++) begin
      @(negedge clk);
      #2;
      drained = (expQ.size() == 0) && (pendQ.size() == 0) && !stale && !dataValid;
    end
    chk(drained, "R5", $sformatf("drain of scenario %0d got 0 exp 1", sc));
    chk(writes - startWrites == accepted, "R5",
        $sformatf("writes got %0d exp %0d", writes - startWrites, accepted));
    chk(expCyc.size() == 0, "R8", $sformatf("pending data slots got %0d exp 0", expCyc.size()));
    chk(!queueFull && !reqValid, "R2",
        $sformatf("idle flags got full=%0b req=%0b exp 0 0", queueFull, reqValid));
  endtask

  initial begin
    int sc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(queueFull == 1'b0, "R1", $sformatf("queueFull got %0b exp 0", queueFull));
    chk(reqValid == 1'b0, "R1", $sformatf("reqValid got %0b exp 0", reqValid));
    chk(dataValid == 1'b0, "R1", $sformatf("dataValid got %0b exp 0", dataValid));
    rstN = 1;
    @(negedge clk);
    chk(!queueFull && !reqValid && !dataValid, "R1", "outputs after release got active exp idle");
    sc = 1;
    // Sweep of the missing slot (slot 8 = no miss) under two latencies.
    for (int lat = 1; lat <= 3; lat += 2) begin
      for (int m = 0; m <= 8; m++) begin
        runBurst(sc, lat, 9'(1 << m), DEPTH, 0);
        sc++;
      end
    end
    runBurst(sc, 2, 9'b0_0010_0100, DEPTH, 0); sc++;
    runBurst(sc, 1, 9'b0_1000_0001, DEPTH, 0); sc++;
    runBurst(sc, 4, 9'b0_0000_0110, 5, 0);     sc++;
    runBurst(sc, 40, 9'b0, DEPTH + 1, 1);      sc++;
    runBurst(sc, 1, 9'b0_0001_0000, DEPTH, 0); sc++;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule